// File: doc/BRIEF.md
# Framed Manchester Line Encoder

This block turns a stream of 16-bit samples into a continuous Manchester-coded serial line signal, ready for a differential line driver. Every frame lasts 48 bit periods. A long run of zero bits lets a receiver regain lock, a single one-valued start bit marks the frame, and then the sample's 16 bits follow, most significant first. Each bit period is built from two half-bit registered values. The line level is the data bit XORed with a half-bit clock phase, and that result is captured in a flip-flop, so the output cannot glitch and averages a 50 % duty cycle.

The system supplies a single-cycle enable `half_en` at twice the bit rate; at a 1 MHz bit rate that gives one sample every 48 µs. Samples enter through a valid/ready port that has a one-entry slot. A sample is accepted when `smp_valid` and `smp_ready` are both high on a clock edge. `smp_ready` then stays low until the next frame boundary moves the sample into the frame register. A source that sees `smp_ready` low must hold its valid and data; this port ignores them until `smp_ready` returns. If no new sample is waiting at a boundary, the previous sample is sent again. After reset the line carries only zero bits, start position included, until the first sample has been loaded.

Top module: `manchester_frame_tx`

## Requirements
- R1: Each bit period consists of two half periods at opposite levels. A 1 is sent low-then-high and a 0 is sent high-then-low.
- R2: A frame is 48 bit periods, with bit period 0 first. Periods 0..30 carry 0, period 31 carries the start bit 1, and periods 32..47 carry sample bits 15 down to 0, so period 32 holds bit 15.
- R3: `line_out` changes only on the clock edge that follows a cycle with `half_en` high. On that edge it takes the level of the half period that begins.
- R4: After reset `line_out` is 0 and `smp_ready` is 1. Until a first sample has been loaded, every bit period, the start position included, is sent as 0.
- R5: A sample is accepted on an edge where `smp_valid` and `smp_ready` are both high, and `smp_ready` is low in the next cycle.
- R6: A waiting sample moves into the frame register only at the end of the second half of bit period 47. `smp_ready` rises only on that edge.
- R7: When no sample is waiting at a frame boundary, the next frame repeats the previous sample's bits.
- R8: While `smp_ready` is low, `smp_valid` and `smp_data` have no effect on any later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Half-bit-period enable, one cycle wide, at twice the bit rate |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample slot empty, able to accept |
| smp_data | input | 16 | Sample value |
| line_out | output | 1 | Manchester-coded line bit, registered |

## Verification
The bench targets the frame boundary. A design that loads a sample mid-frame would splice two samples together, and one that frees the slot early would raise `smp_ready` before bit period 47 ends. It also offers a second sample while the slot is full; a design that lets that sample overwrite the slot sends the wrong word in the next frame. The idle period after reset, all-zero and all-one samples, and a walking single one check that the start position stays low before the first load, that the bits come out MSB first, and that every bit period has its mid-bit transition in the right direction.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} half_t;
endpackage

// File: rtl/mtx_bit_timer.sv
module mtx_bit_timer
  import mtx_pkg::*;
#(
  parameter int FRAME_LEN = 48,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  output half_t            phase,
  output logic [CNT_W-1:0] bit_idx,
  output logic             frame_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  assign frame_end = half_en && (phase == HALF_B) && (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= HALF_A;
      bit_idx <= '0;
    end else if (half_en) begin
      if (phase == HALF_A) begin
        phase <= HALF_B;
      end else begin
        phase   <= HALF_A;
        bit_idx <= (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtx_sample_slot.sv
module mtx_sample_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              frame_end,
  output logic [DATA_W-1:0] frame_q,
  output logic              running
);
  logic              held;
  logic [DATA_W-1:0] held_data;

  assign in_ready = !held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_data <= '0;
      frame_q   <= '0;
      running   <= 1'b0;
    end else begin
      if (frame_end && held) begin
        frame_q <= held_data;
        running <= 1'b1;
        held    <= 1'b0;
      end else if (in_valid && in_ready) begin
        held_data <= in_data;
        held      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtx_line_enc.sv
module mtx_line_enc
  import mtx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ZERO_RUN = 31,
  parameter int CNT_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_en,
  input  half_t             phase,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] frame_q,
  input  logic              running,
  output logic              line_q
);
  localparam logic [CNT_W-1:0] START_POS = CNT_W'(ZERO_RUN);

  logic cur_bit;

  always_comb begin
    cur_bit = 1'b0;
    if (bit_idx == START_POS) cur_bit = running;
    for (int i = 0; i < DATA_W; i++) begin
      if (bit_idx == CNT_W'(ZERO_RUN + 1 + i)) cur_bit = running & frame_q[DATA_W-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       line_q <= 1'b0;
    else if (half_en) line_q <= cur_bit ^ (phase == HALF_A);
  end
endmodule

// File: rtl/manchester_frame_tx.sv
module manchester_frame_tx
  import mtx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ZERO_RUN = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_en,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              line_out
);
  localparam int FRAME_LEN = ZERO_RUN + 1 + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  half_t             phase;
  logic [CNT_W-1:0]  bit_idx;
  logic              frame_end;
  logic [DATA_W-1:0] frame_q;
  logic              running;

  mtx_bit_timer #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .phase(phase), .bit_idx(bit_idx), .frame_end(frame_end)
  );

  mtx_sample_slot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_ready(smp_ready),
    .in_data(smp_data), .frame_end(frame_end), .frame_q(frame_q), .running(running)
  );

  mtx_line_enc #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN), .CNT_W(CNT_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .phase(phase), .bit_idx(bit_idx),
    .frame_q(frame_q), .running(running), .line_q(line_out)
  );
endmodule

// File: rtl/manchester_frame_tx_chk.sv
module manchester_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic half_en,
  input logic smp_valid,
  input logic smp_ready,
  input logic line_out
);
  logic second_half;

  always_ff @(posedge clk) begin
    if (!rst_n)       second_half <= 1'b0;
    else if (half_en) second_half <= !second_half;
  end

  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(line_out));

  assert_mid_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && second_half) |=> (line_out != $past(line_out)));

  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  assert_ready_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && !(half_en && second_half)) |=> !smp_ready);
endmodule

bind manchester_frame_tx manchester_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .line_out(line_out)
);

// File: tb/tb_manchester_frame_tx.sv
`timescale 1ns/1ps
module tb_manchester_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_en = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        line_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          m_k = 0;
  bit          m_run = 1'b0;
  bit          m_pv = 1'b0;
  logic [15:0] m_frame = '0;
  logic [15:0] m_pend = '0;
  logic        prev_line = 1'b0;

  always #2.5 clk = ~clk;

  manchester_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .line_out(line_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (half %0d)", req, act, exp, m_k);
    end
  endtask

  function automatic bit exp_bit(input int idx);
    if (idx < 31)  return 1'b0;
    if (idx == 31) return m_run;
    return m_run & m_frame[15 - (idx - 32)];
  endfunction

  // one half period: pulse half_en, check new line level and ready
  task automatic half_step();
    int  idx;
    bit  second;
    bit  e;
    idx    = (m_k / 2) % 48;
    second = (m_k % 2) == 1;
    e      = exp_bit(idx) ^ !second;   // R1: 1 -> low,high ; 0 -> high,low
    @(negedge clk) half_en = 1'b1;
    @(negedge clk) half_en = 1'b0;
    if (idx < 31 || !m_run) chk(line_out == e, "R4/R2 zero run", line_out, e);
    else                    chk(line_out == e, "R2 frame bit", line_out, e);
    if (second) chk(line_out != prev_line, "R1 mid-bit flip", line_out, !prev_line);
    prev_line = line_out;
    if (second && idx == 47 && m_pv) begin
      m_frame = m_pend; m_run = 1'b1; m_pv = 1'b0;   // R6
    end
    chk(smp_ready == !m_pv, "R6 ready at boundary", smp_ready, !m_pv);
    m_k++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) half_step();
  endtask

  // offer a sample for one cycle (between half_en pulses)
  task automatic offer(input logic [15:0] d);
    bit rdy;
    @(negedge clk);
    rdy = smp_ready;
    chk(rdy == !m_pv, "R5 ready before offer", rdy, !m_pv);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0; smp_data = 16'h0;
    // R3: no half_en in that cycle, so line level must not move
    chk(line_out == prev_line, "R3 line held without half_en", line_out, prev_line);
    if (rdy) begin
      m_pend = d; m_pv = 1'b1;
      chk(smp_ready == 1'b0, "R5 ready low after accept", smp_ready, 0);
    end else begin
      chk(smp_ready == 1'b0, "R8 ready still low", smp_ready, 0);
    end
  endtask

  // advance to the start of the next frame
  task automatic to_boundary();
    while ((m_k % 96) != 0) half_step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_out == 1'b0, "R4 reset line", line_out, 0);
    chk(smp_ready == 1'b1, "R4 reset ready", smp_ready, 1);

    steps(96 + 40);                 // R4: idle frame then part of the next
    offer(16'hA5C3);                // R5 accept mid-frame
    steps(3);
    offer(16'h5A5A);                // R8 ignored while slot full
    to_boundary();                  // R6 load at boundary
    steps(96);                      // frame with A5C3
    steps(96);                      // R7 repeated frame

    // sweep: all-zero, all-one, walking one, mixed
    offer(16'h0000); to_boundary(); steps(96);
    offer(16'hFFFF); to_boundary(); steps(96);
    for (int b = 0; b < 16; b++) begin
      steps(10);
      offer(16'h1 << b);
      to_boundary();
    end
    steps(96);
    offer(16'h8001); steps(180); offer(16'h1234);  // offer late in frame
    to_boundary(); steps(96);
    offer(16'h7FFE);
    steps(2);
    offer(16'hBEEF);                // R8 again
    to_boundary(); steps(192);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule